// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block sits between an internal requester and an external asynchronous memory that supports page-mode reads. The requester offers one byte read at a time, each with a 24-bit address, over a valid/ready handshake. The sequencer drives the external address bus, an active-low read strobe and an active-low chip select. It captures the 8-bit read data and returns it with a one-cycle valid pulse.

An access that opens a page is slower on such memories than an access to a byte in a page that is already open. The sequencer keeps a record of the open page. When page mode is on and a new request arrives in the last cycle of a pulse and falls in that page, both strobes stay low and only the address changes. That access then uses the shorter in-page pulse length. A request outside the open page, or any request while page mode is off, closes the burst. Both strobes go high for exactly one cycle and the next access uses the longer first-access pulse. When no request is waiting as a pulse ends, the strobes go high and the sequencer returns to idle.

The controller has three states. ST_IDLE has the strobes high and ready asserted. ST_PULSE has the strobes low while a down-counter times the pulse. ST_GAP holds the strobes high for one cycle between pages. The transitions are:
- ST_IDLE to ST_PULSE on an accepted request (accept-first).
- ST_PULSE to itself when its last cycle accepts a page hit (accept-hit).
- ST_PULSE to ST_GAP when its last cycle accepts a miss (accept-miss).
- ST_PULSE to ST_IDLE when its last cycle finds no request (drain).
- ST_GAP to ST_PULSE always (reopen).

Top module: `pgrd_seq`

## Requirements
- R1: After reset, mem_rd_n and mem_cs_n are 1, rsp_valid is 0 and req_ready is 1.
- R2: cfg_page_sel codes 0, 1, 2, 3 select pages of 4, 8, 16, 32 bytes aligned to their size. Two addresses share a page when bits 23 down to 2+cfg_page_sel are equal.
- R3: An access that opens a page holds both strobes low for max(1, cfg_first_len) cycles.
- R4: With cfg_page_en at 1, a request accepted in the last pulse cycle that shares the open page keeps both strobes low with no high cycle and lasts max(1, cfg_hit_len) cycles.
- R5: With cfg_page_en at 1, a request accepted in the last pulse cycle that lies outside the open page puts both strobes high for exactly one cycle, then starts a first-access pulse.
- R6: With cfg_page_en at 0, every access is a first access, and back-to-back accesses are separated by exactly one cycle with the strobes high.
- R7: mem_rd_n and mem_cs_n carry the same value in every cycle.
- R8: mem_data is sampled in the last cycle of each pulse and appears on rsp_data with rsp_valid high in the next cycle, one pulse per access, in request order.
- R9: A pulse-length input of 0 gives a one-cycle pulse.
- R10: req_ready is 1 only in ST_IDLE or in the last cycle of a pulse. mem_addr does not change inside a pulse.
- R11: When a pulse ends with no request waiting, both strobes go high in the next cycle and the next access opens a new page even if its address shares the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 1 | Page-mode enable |
| cfg_page_sel | input | 2 | Page size code: 0=4, 1=8, 2=16, 3=32 bytes |
| cfg_first_len | input | 6 | First-access pulse length in cycles |
| cfg_hit_len | input | 6 | In-page pulse length in cycles |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 24 | Byte address of the request |
| mem_addr | output | 24 | External address bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_data | input | 8 | External read data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | 8 | Read data returned |

## Verification
Two events share the last cycle of a pulse. The data of the ending access is sampled, and the next request is accepted and judged hit or miss. The bench provokes this by holding req_valid high with the next address as soon as each handshake completes, so every pulse's last cycle also carries a new request. A monitor measures each low run and the high run before it from the ports. When rsp_valid rises, it compares the returned byte, the pulse length and the strobe gap with the item the driver queued. That catches a data capture taken from the wrong access and a hit decision made against the wrong page.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } pgrd_state_e;
endpackage

// File: rtl/pgrd_page_match.sv
module pgrd_page_match #(
    parameter int ADDR_W       = 24,
    parameter int SEL_W        = 2,
    parameter int MIN_PAGE_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_en,
    input  logic              burst_open,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              store,
    output logic              hit
);
    logic [ADDR_W-1:0] open_page;
    logic [ADDR_W-1:0] tag_mask;
    logic [5:0]        low_bits;

    assign low_bits = 6'(MIN_PAGE_LOG) + 6'(page_sel);

    // keep only the bits above the in-page offset
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign tag_mask[i] = (6'(i) >= low_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            open_page <= '0;
        else if (store)
            open_page <= req_addr;
    end

    assign hit = page_en && burst_open &&
                 (((req_addr ^ open_page) & tag_mask) == '0);

    // R2
    top_bits_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_addr[ADDR_W-1:MIN_PAGE_LOG+(1<<SEL_W)-1]
                 == open_page[ADDR_W-1:MIN_PAGE_LOG+(1<<SEL_W)-1]));
endmodule

// File: rtl/pgrd_pulse_timer.sv
module pgrd_pulse_timer #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= (len == '0) ? '0 : len - 1'b1;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign last = (remain == '0);

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 6,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_page_en,
    input  logic [SEL_W-1:0]  cfg_page_sel,
    input  logic [LEN_W-1:0]  cfg_first_len,
    input  logic [LEN_W-1:0]  cfg_hit_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic              mem_cs_n,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    pgrd_state_e state_q, state_d;
    logic        accept;
    logic        hit;
    logic        last;
    logic        tmr_load;
    logic        use_hit_len;
    logic [LEN_W-1:0] load_len;
    logic        burst_open;

    assign burst_open = (state_q == ST_PULSE);

    pgrd_page_match #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .MIN_PAGE_LOG(2)
    ) u_match (
        .clk(clk), .rst_n(rst_n),
        .page_en(cfg_page_en), .burst_open(burst_open),
        .page_sel(cfg_page_sel), .req_addr(req_addr),
        .store(accept), .hit(hit)
    );

    assign load_len = use_hit_len ? cfg_hit_len : cfg_first_len;

    pgrd_pulse_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .len(load_len), .last(last)
    );

    // next-state and control decode
    always_comb begin
        state_d     = state_q;
        req_ready   = 1'b0;
        accept      = 1'b0;
        tmr_load    = 1'b0;
        use_hit_len = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (last) begin
                    req_ready = 1'b1;
                    if (req_valid && hit) begin
                        accept      = 1'b1;
                        tmr_load    = 1'b1;
                        use_hit_len = 1'b1;
                    end else if (req_valid) begin
                        accept  = 1'b1;
                        state_d = ST_GAP;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                tmr_load = 1'b1;
                state_d  = ST_PULSE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state, address and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= (state_q == ST_PULSE) && last;
            if (accept)
                mem_addr <= req_addr;
            if ((state_q == ST_PULSE) && last)
                rsp_data <= mem_data;
        end
    end

    // strobe outputs
    always_comb begin
        mem_rd_n = (state_q != ST_PULSE);
        mem_cs_n = (state_q != ST_PULSE);
    end

    // R5
    miss_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_page_en && req_ready && req_valid && !mem_rd_n && !hit) |=> mem_rd_n);

    // R4
    hit_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !mem_rd_n && hit) |=> !mem_rd_n);

    // R6
    nopage_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_page_en && req_ready && req_valid && !mem_rd_n) |=> mem_rd_n);

    // R11
    drain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && req_ready && !req_valid) |=> mem_rd_n);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !req_ready) |=> $stable(mem_addr));

    // R8
    rsp_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(!mem_rd_n));
endmodule

// File: tb/pgrd_seq_test.sv
module pgrd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_page_en = 1'b1;
    logic [1:0]  cfg_page_sel = 2'd0;
    logic [5:0]  cfg_first_len = 6'd5;
    logic [5:0]  cfg_hit_len = 6'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [23:0] mem_addr;
    logic        mem_rd_n, mem_cs_n;
    logic [7:0]  mem_data;
    logic        rsp_valid;
    logic [7:0]  rsp_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign mem_data = mem_addr[7:0] ^ mem_addr[15:8] ^ mem_addr[23:16] ^ 8'h5A;

    pgrd_seq uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_page_en(cfg_page_en), .cfg_page_sel(cfg_page_sel),
        .cfg_first_len(cfg_first_len), .cfg_hit_len(cfg_hit_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n),
        .mem_data(mem_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // expected items: kind 0 = opens after idle, 1 = miss in burst,
    // 2 = page hit, 3 = page mode off back-to-back
    logic [7:0] q_data[$];
    int         q_len[$];
    int         q_kind[$];
    bit         q_zero[$];

    bit          burst_open = 1'b0;
    logic [23:0] prev_req = '0;

    function automatic logic [7:0] model_data(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic send(input logic [23:0] a, input bit idle_first);
        int kind;
        int raw;
        int sh;
        if (idle_first) begin
            req_valid = 1'b0;
            repeat (80) @(negedge clk);
            burst_open = 1'b0;
        end
        sh = 2 + int'(cfg_page_sel);
        if (!burst_open)                kind = 0;
        else if (!cfg_page_en)          kind = 3;
        else if ((a >> sh) == (prev_req >> sh)) kind = 2;
        else                            kind = 1;
        raw = (kind == 2) ? int'(cfg_hit_len) : int'(cfg_first_len);
        q_data.push_back(model_data(a));
        q_len.push_back(raw == 0 ? 1 : raw);
        q_kind.push_back(kind);
        q_zero.push_back(raw == 0);
        req_addr  = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        burst_open = 1'b1;
        prev_req   = a;
    endtask

    task automatic flush();
        int guard;
        req_valid = 1'b0;
        guard = 0;
        while (q_data.size() != 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        burst_open = 1'b0;
    endtask

    // monitor
    bit          prev_low = 1'b0;
    logic [23:0] mon_addr = '0;
    int          run = 0;
    int          hrun = 0;
    int          start_high = 0;
    int          start_hlen = 0;
    int          done_len = 0;
    int          done_sh = 0;
    int          done_hlen = 0;
    bit          prev_ready_low = 1'b0;
    int          r7_bad = 0;
    int          r10_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ended;
            if (mem_rd_n !== mem_cs_n) r7_bad++;
            ended = prev_low && (mem_rd_n || mem_addr != mon_addr);
            if (prev_ready_low && !ended) r10_bad++;
            if (prev_low && !ended && mem_addr != mon_addr) r10_bad++;
            if (ended) begin
                done_len  = run;
                done_sh   = start_high;
                done_hlen = start_hlen;
            end
            if (!mem_rd_n) begin
                if (ended || !prev_low) begin
                    start_high = prev_low ? 0 : 1;
                    start_hlen = prev_low ? 0 : hrun;
                    run = 1;
                end else begin
                    run++;
                end
                hrun = 0;
            end else begin
                hrun++;
            end
            prev_ready_low = req_ready && !mem_rd_n;
            prev_low = !mem_rd_n;
            mon_addr = mem_addr;
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R8: unexpected response %h, expected none", rsp_data);
                end else begin
                    logic [7:0] ed;
                    int el, ek;
                    bit ez;
                    ed = q_data.pop_front();
                    el = q_len.pop_front();
                    ek = q_kind.pop_front();
                    ez = q_zero.pop_front();
                    tests++;
                    if (rsp_data !== ed) begin
                        fails++;
                        $display("FAIL R8: data %h expected %h", rsp_data, ed);
                    end
                    tests++;
                    if (done_len != el) begin
                        fails++;
                        if (ez)
                            $display("FAIL R9: pulse %0d expected %0d", done_len, el);
                        else if (ek == 2)
                            $display("FAIL R4: hit pulse %0d expected %0d", done_len, el);
                        else
                            $display("FAIL R3: first pulse %0d expected %0d", done_len, el);
                    end
                    tests++;
                    if (ek == 2 && done_sh != 0) begin
                        fails++;
                        $display("FAIL R4: strobe rose before hit, got %0d expected 0", done_sh);
                    end else if (ek != 2 && done_sh != 1) begin
                        fails++;
                        if (ek == 0)
                            $display("FAIL R11: no high before new burst, got %0d expected 1", done_sh);
                        else if (ek == 1)
                            $display("FAIL R5: no high on miss, got %0d expected 1", done_sh);
                        else
                            $display("FAIL R6: no high with page mode off, got %0d expected 1", done_sh);
                    end else if ((ek == 1 || ek == 3) && done_hlen != 1) begin
                        fails++;
                        if (ek == 1)
                            $display("FAIL R5: high gap %0d expected 1", done_hlen);
                        else
                            $display("FAIL R6: high gap %0d expected 1", done_hlen);
                    end
                end
            end
        end
    end

    task automatic set_cfg(input bit en, input logic [1:0] sel,
                           input logic [5:0] fl, input logic [5:0] hl);
        cfg_page_en   = en;
        cfg_page_sel  = sel;
        cfg_first_len = fl;
        cfg_hit_len   = hl;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        tests++;
        if (mem_rd_n !== 1'b1 || mem_cs_n !== 1'b1 || rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1: rd_n=%b cs_n=%b rsp_valid=%b ready=%b expected 1 1 0 1",
                     mem_rd_n, mem_cs_n, rsp_valid, req_ready);
        end

        // R2 R3 R4 R5: 4-byte pages
        set_cfg(1'b1, 2'd0, 6'd5, 6'd2);
        send(24'h000100, 1'b1);
        send(24'h000101, 1'b0);
        send(24'h000103, 1'b0);
        send(24'h000104, 1'b0);
        send(24'h000106, 1'b0);
        flush();

        // R2: 32-byte pages
        set_cfg(1'b1, 2'd3, 6'd4, 6'd3);
        send(24'h001000, 1'b1);
        send(24'h00101F, 1'b0);
        send(24'h001003, 1'b0);
        send(24'h001020, 1'b0);
        send(24'h00103F, 1'b0);
        flush();

        // R2: 8-byte and 16-byte pages
        set_cfg(1'b1, 2'd1, 6'd3, 6'd2);
        send(24'h002007, 1'b1);
        send(24'h002000, 1'b0);
        send(24'h002008, 1'b0);
        flush();
        set_cfg(1'b1, 2'd2, 6'd3, 6'd2);
        send(24'h00300F, 1'b1);
        send(24'h003000, 1'b0);
        send(24'h003010, 1'b0);
        flush();

        // R6: page mode off
        set_cfg(1'b0, 2'd3, 6'd3, 6'd1);
        send(24'h004000, 1'b1);
        send(24'h004001, 1'b0);
        send(24'h004002, 1'b0);
        flush();

        // R9: zero lengths
        set_cfg(1'b1, 2'd0, 6'd0, 6'd0);
        send(24'h005000, 1'b1);
        send(24'h005001, 1'b0);
        send(24'h005002, 1'b0);
        send(24'h005004, 1'b0);
        flush();

        // R11: idle between requests in one page
        set_cfg(1'b1, 2'd0, 6'd3, 6'd1);
        send(24'h006000, 1'b1);
        send(24'h006001, 1'b1);
        flush();

        // R3 R4: longest first pulse, one-cycle hits
        set_cfg(1'b1, 2'd1, 6'd63, 6'd1);
        send(24'h007000, 1'b1);
        send(24'h007001, 1'b0);
        send(24'h007002, 1'b0);
        flush();

        // R7
        tests++;
        if (r7_bad != 0) begin
            fails++;
            $display("FAIL R7: %0d cycles with rd_n != cs_n, expected 0", r7_bad);
        end
        // R10
        tests++;
        if (r10_bad != 0) begin
            fails++;
            $display("FAIL R10: %0d ready/address violations, expected 0", r10_bad);
        end
        tests++;
        if (q_data.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d responses missing, expected 0", q_data.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8: watchdog expired, got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule